// File: doc/BRIEF.md
# Byte-Stuffing Frame Encoder

This block turns a raw byte stream into a framed, escaped byte stream. A level input marks when a frame is in progress. When that level rises, the block sends an opening delimiter. When it falls, the block sends a closing delimiter. Payload bytes are taken only while a frame is open. Three byte values are reserved: the opening delimiter, the closing delimiter and the escape code. A payload byte that matches any of them goes out as two bytes: the escape code, then the bitwise complement of the original byte.

Both sides use a valid/ready handshake. The output side is built to feed a FIFO write port. One payload byte can grow into two output bytes. To absorb this, the block lowers its input ready for the cycle in which it sends the complement byte. Input can therefore arrive on every cycle without any byte being lost. All state is cleared by a synchronous active-high reset.

Top module: `fenc_encoder`

## Requirements
- R1: In the first cycle after reset, out_valid and in_ready are both low, and no frame is open.
- R2: After frame_active rises, the first byte sent is the opening delimiter (default 0x7D). It precedes every payload byte of that frame.
- R3: After frame_active falls, the closing delimiter (default 0x5D) is sent after the last output byte of the frame. This includes a complement byte that is still pending.
- R4: A payload byte equal to 0x7D, 0x5D or the escape code (default 0xDB) is sent as the escape code followed by its bitwise complement.
- R5: Every other payload byte is sent unchanged, and all bytes keep their input order.
- R6: In the cycle after a reserved payload byte is accepted, in_ready is low.
- R7: in_ready is low whenever out_ready is low, whenever frame_active is low, and whenever no frame is open.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value.
- R9: A frame that carries no payload produces the opening delimiter immediately followed by the closing delimiter.
- R10: With out_ready held high and input offered on every cycle, the only stall cycles inside a frame are one per reserved payload byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_active | input | 1 | Level that is high for the duration of a frame |
| in_valid | input | 1 | Input byte is present |
| in_data | input | DATA_W | Input payload byte |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte is present |
| out_data | output | DATA_W | Output byte: delimiter, escape, complement or payload |
| out_ready | input | 1 | Downstream accepts the output byte this cycle |

## Verification
The assertions and the stream check make two assumptions about the inputs. First, frame_active stays high until the opening delimiter has left the output. Second, once frame_active drops, it stays low until the closing delimiter has left. A level pulse shorter than a stalled output slot is therefore out of scope. The stimulus follows this rule: it raises the level, watches the output for the opening delimiter before it lowers the level again, and then waits for the closing delimiter before it starts the next frame. Input bytes are offered only while the level is high, and out_ready is varied randomly in some phases and held high in others.

// File: rtl/fenc_pkg.sv
package fenc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_COMP = 2'd2
   } fenc_state_e;

   localparam int unsigned FENC_NUM_CODES = 3;

endpackage

// File: rtl/fenc_code_match.sv
module fenc_code_match #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned NUM_CODES = 3,
   parameter logic [NUM_CODES*DATA_W-1:0] CODES = '0
) (
   input  logic [DATA_W-1:0] byte_in,
   output logic              hit
);

   logic [NUM_CODES-1:0] hit_vec;

   for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
      assign hit_vec[g] = (byte_in == CODES[g*DATA_W +: DATA_W]);
   end

   assign hit = |hit_vec;

endmodule

// File: rtl/fenc_out_reg.sv
module fenc_out_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_data  <= load_data;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/fenc_ctrl.sv
module fenc_ctrl
   import fenc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] START_CODE = 8'h7D,
   parameter logic [DATA_W-1:0] STOP_CODE  = 8'h5D,
   parameter logic [DATA_W-1:0] ESC_CODE   = 8'hDB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_active,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              reserved_hit,
   input  logic              out_valid,
   input  logic              out_ready,
   output logic              in_ready,
   output logic              load,
   output logic [DATA_W-1:0] load_data
);

   fenc_state_e       state_q, state_d;
   logic [DATA_W-1:0] comp_q, comp_d;
   logic              slot_free;
   logic              take;

   assign slot_free = !out_valid || out_ready;
   assign in_ready  = (state_q == ST_OPEN) && frame_active && out_ready;
   assign take      = in_valid && in_ready;

   always_comb begin
      state_d   = state_q;
      comp_d    = comp_q;
      load      = 1'b0;
      load_data = in_data;
      unique case (state_q)
         ST_IDLE: begin
            if (frame_active && slot_free) begin
               load      = 1'b1;
               load_data = START_CODE;
               state_d   = ST_OPEN;
            end
         end
         ST_OPEN: begin
            if (!frame_active) begin
               if (slot_free) begin
                  load      = 1'b1;
                  load_data = STOP_CODE;
                  state_d   = ST_IDLE;
               end
            end else if (take) begin
               load = 1'b1;
               if (reserved_hit) begin
                  load_data = ESC_CODE;
                  comp_d    = ~in_data;
                  state_d   = ST_COMP;
               end else begin
                  load_data = in_data;
               end
            end
         end
         ST_COMP: begin
            if (slot_free) begin
               load      = 1'b1;
               load_data = comp_q;
               state_d   = ST_OPEN;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         comp_q  <= '0;
      end else begin
         state_q <= state_d;
         comp_q  <= comp_d;
      end
   end

endmodule

// File: rtl/fenc_encoder.sv
module fenc_encoder
   import fenc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] START_CODE = 8'h7D,
   parameter logic [DATA_W-1:0] STOP_CODE  = 8'h5D,
   parameter logic [DATA_W-1:0] ESC_CODE   = 8'hDB
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              frame_active,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready
);

   localparam logic [FENC_NUM_CODES*DATA_W-1:0] CODE_SET = {ESC_CODE, STOP_CODE, START_CODE};

   if (DATA_W < 2) begin : g_bad_width
      $error("fenc_encoder: DATA_W must be at least 2");
   end
   if (START_CODE == STOP_CODE || START_CODE == ESC_CODE || STOP_CODE == ESC_CODE) begin : g_bad_codes
      $error("fenc_encoder: delimiter and escape codes must all differ");
   end

   logic              hit;
   logic              load;
   logic [DATA_W-1:0] load_data;

   fenc_code_match #(
      .DATA_W   (DATA_W),
      .NUM_CODES(FENC_NUM_CODES),
      .CODES    (CODE_SET)
   ) match_i (
      .byte_in(in_data),
      .hit    (hit)
   );

   fenc_ctrl #(
      .DATA_W    (DATA_W),
      .START_CODE(START_CODE),
      .STOP_CODE (STOP_CODE),
      .ESC_CODE  (ESC_CODE)
   ) ctrl_i (
      .clk         (clk),
      .rst         (rst),
      .frame_active(frame_active),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .reserved_hit(hit),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .in_ready    (in_ready),
      .load        (load),
      .load_data   (load_data)
   );

   fenc_out_reg #(
      .DATA_W(DATA_W)
   ) oreg_i (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_data(load_data),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .out_data (out_data)
   );

endmodule

// File: rtl/fenc_encoder_chk.sv
module fenc_encoder_chk #(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] START_CODE = 8'h7D,
   parameter logic [DATA_W-1:0] STOP_CODE  = 8'h5D,
   parameter logic [DATA_W-1:0] ESC_CODE   = 8'hDB
) (
   input logic              clk,
   input logic              rst,
   input logic              frame_active,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic              in_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_ready
);

   logic reserved_in;
   assign reserved_in = (in_data == START_CODE) || (in_data == STOP_CODE) || (in_data == ESC_CODE);

   assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !in_ready));

   assert_comp_stall_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && reserved_in) |=> !in_ready);

   assert_no_accept_blocked_R7: assert property (@(posedge clk) disable iff (rst)
      (!out_ready || !frame_active) |-> !in_ready);

   assert_hold_output_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   assert_escape_not_raw_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && reserved_in) |=> (out_valid && out_data == ESC_CODE));

endmodule

bind fenc_encoder fenc_encoder_chk #(
   .DATA_W    (DATA_W),
   .START_CODE(START_CODE),
   .STOP_CODE (STOP_CODE),
   .ESC_CODE  (ESC_CODE)
) chk_i (
   .clk         (clk),
   .rst         (rst),
   .frame_active(frame_active),
   .in_valid    (in_valid),
   .in_data     (in_data),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_data    (out_data),
   .out_ready   (out_ready)
);

// File: tb/fenc_encoder_tb.sv
module fenc_encoder_tb_top;

   localparam logic [7:0] K_START = 8'h7D;
   localparam logic [7:0] K_STOP  = 8'h5D;
   localparam logic [7:0] K_ESC   = 8'hDB;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       frame_active = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_ready = 1'b1;

   int checks = 0;
   int bad = 0;
   int start_cnt = 0;
   int stop_cnt = 0;
   int cycles = 0;
   int stall_cnt = 0;
   bit rand_ready = 1'b0;
   bit prev_rsv_take = 1'b0;
   bit prev_hold = 1'b0;
   logic [7:0] prev_out = '0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   fenc_encoder dut_i (
      .clk         (clk),
      .rst         (rst),
      .frame_active(frame_active),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .out_ready   (out_ready)
   );

   function automatic bit is_reserved(logic [7:0] b);
      return (b == K_START) || (b == K_STOP) || (b == K_ESC);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: sample between edges, transfers happen at the following posedge
   always @(negedge clk) begin
      if (!rst) begin
         if (prev_rsv_take) check(!in_ready, "R6", in_ready, 0);
         if (prev_hold) check(out_valid && out_data == prev_out, "R8", out_data, prev_out);
         if (!out_ready || !frame_active) check(!in_ready, "R7", in_ready, 0);
         if (in_valid && !in_ready && frame_active && out_ready) stall_cnt++;
         prev_rsv_take = in_valid && in_ready && is_reserved(in_data);
         prev_hold = out_valid && !out_ready;
         prev_out = out_data;
         if (in_valid && in_ready) begin
            if (is_reserved(in_data)) begin
               exp_q.push_back(K_ESC);    tag_q.push_back("R4");
               exp_q.push_back(~in_data); tag_q.push_back("R4");
            end else begin
               exp_q.push_back(in_data);  tag_q.push_back("R5");
            end
         end
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5", out_data, 0);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(out_data == e, t, out_data, e);
            end
            if (out_data == K_START) start_cnt++;
            if (out_data == K_STOP) stop_cnt++;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rand_ready) out_ready = ($urandom_range(0, 9) < 7);
      else out_ready = 1'b1;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         bad++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic open_frame();
      int s;
      s = start_cnt;
      frame_active = 1'b1;
      exp_q.push_back(K_START); tag_q.push_back("R2");
      while (start_cnt == s) @(negedge clk);
      step();
   endtask

   task automatic close_frame();
      int s;
      s = stop_cnt;
      frame_active = 1'b0;
      exp_q.push_back(K_STOP); tag_q.push_back("R3");
      while (stop_cnt == s) @(negedge clk);
      step();
      check(exp_q.size() == 0, "R3", exp_q.size(), 0);
   endtask

   task automatic send_byte(logic [7:0] b);
      in_valid = 1'b1;
      in_data = b;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      step();
      in_valid = 1'b0;
   endtask

   function automatic logic [7:0] rand_byte();
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
         0: return K_START;
         1: return K_STOP;
         2: return K_ESC;
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      logic [7:0] burst[6];
      int nres;
      void'($urandom(32'd1234));
      burst = '{8'h11, 8'h7D, 8'h22, 8'h5D, 8'hDB, 8'h33};
      repeat (4) step();
      rst = 1'b0;
      @(negedge clk);
      check(!out_valid && !in_ready, "R1", {out_valid, in_ready}, 0);
      step();

      // R9: empty frame
      open_frame();
      close_frame();

      // R10 and R4: back-to-back input with reserved bytes, out_ready high
      open_frame();
      stall_cnt = 0;
      in_valid = 1'b1;
      nres = 0;
      for (int i = 0; i < 6; i++) begin
         in_data = burst[i];
         if (is_reserved(burst[i])) nres++;
         @(negedge clk);
         while (!in_ready) @(negedge clk);
         step();
      end
      in_valid = 1'b0;
      check(stall_cnt == nres, "R10", stall_cnt, nres);
      close_frame();

      // R3: reserved byte last, frame closed right after acceptance
      open_frame();
      send_byte(8'h44);
      send_byte(K_ESC);
      close_frame();

      // R8/R7: random output backpressure, random frames
      rand_ready = 1'b1;
      for (int f = 0; f < 40; f++) begin
         int len;
         len = $urandom_range(0, 12);
         open_frame();
         for (int k = 0; k < len; k++) begin
            if ($urandom_range(0, 3) == 0) step();
            send_byte(rand_byte());
         end
         close_frame();
         repeat ($urandom_range(0, 3)) step();
      end
      rand_ready = 1'b0;

      // R9 again under backpressure-free conditions
      open_frame();
      close_frame();

      repeat (5) step();
      check(!out_valid && exp_q.size() == 0, "R5", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule